// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates one 48-bit virtual address at a time into a physical address. It walks a tree of 64-bit table entries held in memory. Each entry is fetched through a single request/acknowledge memory port. The walk starts from a root table base that is captured together with the start pulse. The walk normally descends four levels, but a level-2 entry whose page-size bit is set ends it early as a large-page leaf.

Every entry the walker reads is presented to an external permission checker in the cycle its data returns. The checker answers in that same cycle with a fault flag and an error code. A fault ends the walk at once and reports the level at which it occurred.

A walk that succeeds maintains the accessed and dirty bookkeeping bits in the tables. Each write-back is a read-modify-write of the entry just fetched, and it is issued only when the stored value would change. When the walk completes, the block gives a one-cycle done pulse along with the physical address and the updated leaf entry.

Top module: `page_walker`

## Requirements
- R1: A walk begins at level 4 using `root_base[39:12]`. The entry for level L is read at `{base[39:12], vaddr[12+9*(L-1) +: 9], 3'b000}`.
- R2: When the walk descends below a non-leaf entry, the base for the next level is that entry's bits 39:12, with the low 12 bits cleared.
- R3: A level-1 entry is always a leaf. A level-2 entry is a leaf when its bit 7 (page size) is 1, and then no level-1 read occurs. `chk_leaf` reports this decision.
- R4: Bit 5 is the accessed bit. A non-leaf entry that has bit 5 clear is written back with bit 5 set, at the same address and before the next read. A non-leaf entry that already has bit 5 set is not written.
- R5: A leaf is updated by setting bit 5, and also bit 6 (dirty) when `acc_write` was 1 at start. It is written back only if this changes its value. `leaf_entry` reports the updated value.
- R6: When `chk_fault` is 1 with `chk_valid`, no further memory request is made and no write is issued. Done follows with `fault`=1, `err_code` equal to the returned `chk_code`, and `fault_level` equal to the faulting level. A successful walk reports `fault`=0, `err_code`=0 and `fault_level`=0.
- R7: For a normal leaf, `pa = {entry[39:12], vaddr[11:0]}`. For a large leaf, `pa = {entry[39:22], 1'b0, vaddr[20:0]}`, so base bit 21 is forced to 0.
- R8: The entry passed to the checker has bits 63:59 (protection key) cleared for a non-leaf entry. A leaf entry is passed unchanged.
- R9: `done` is high for exactly one cycle: the cycle after the last accepted memory transfer of the walk. At all other times it is 0.
- R10: A `start` that arrives while a walk is in progress is ignored. The current walk's addresses and results are unaffected.
- R11: Once `mem_req` is raised, it and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is 1.
- R12: After reset, `done` and `mem_req` are 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 48 | Virtual address to translate |
| acc_write | input | 1 | Access is a write (sets dirty on success) |
| root_base | input | 40 | Physical base of the top-level table |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 40 | Entry byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Transfer accepted; read data valid this cycle |
| mem_rdata | input | 64 | Read data |
| chk_valid | output | 1 | An entry is presented to the checker |
| chk_level | output | 3 | Level of the presented entry |
| chk_leaf | output | 1 | Presented entry is the leaf |
| chk_entry | output | 64 | Presented entry (key field cleared if not leaf) |
| chk_fault | input | 1 | Checker reports a fault |
| chk_code | input | 8 | Checker error code |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| err_code | output | 8 | Error code of the fault |
| fault_level | output | 3 | Level of the fault, 0 on success |
| pa | output | 40 | Translated physical address |
| leaf_entry | output | 64 | Leaf entry after update |

## Verification
If the level counter or the stored base is corrupted, the fault shows on `mem_addr` at the very next request, one transfer after the bad value is loaded. A wrong leaf decision shows at once on `chk_leaf` in the same acknowledge cycle, and then as an extra or missing read on the following cycle. Errors in accessed/dirty handling show on the write-back itself, or as a write-back that should not be there, in the cycle right after the entry returns. An error in the offset or frame masking reaches the ports only at the done pulse, through `pa`. The bench therefore compares every request, every checker presentation and every done cycle against its own expected list of transfers.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int LEVELS = 4,
  parameter int PA_W   = 40,
  parameter int E_W    = 64,
  parameter int ERR_W  = 8,
  parameter int A_BIT  = 5,
  parameter int D_BIT  = 6,
  parameter int PS_BIT = 7,
  parameter int PK_LSB = 59,
  localparam int VA_W  = 12 + 9 * LEVELS,
  localparam int LW    = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             acc_write,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [E_W-1:0]   mem_wdata,
  input  logic             mem_ack,
  input  logic [E_W-1:0]   mem_rdata,
  output logic             chk_valid,
  output logic [LW-1:0]    chk_level,
  output logic             chk_leaf,
  output logic [E_W-1:0]   chk_entry,
  input  logic             chk_fault,
  input  logic [ERR_W-1:0] chk_code,
  output logic             done,
  output logic             fault,
  output logic [ERR_W-1:0] err_code,
  output logic [LW-1:0]    fault_level,
  output logic [PA_W-1:0]  pa,
  output logic [E_W-1:0]   leaf_entry
);
  localparam logic [E_W-1:0] A_M  = E_W'(1) << A_BIT;
  localparam logic [E_W-1:0] D_M  = E_W'(1) << D_BIT;
  localparam logic [E_W-1:0] PK_M = ~((E_W'(1) << PK_LSB) - E_W'(1));

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WDIR, S_WLEAF} st_t;

  st_t              st;
  logic [LW-1:0]    lvl;
  logic [PA_W-13:0] base;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [E_W-1:0]   ent_q;
  logic [8:0]       idx;

  always_comb begin
    idx = '0;
    for (int l = 1; l <= LEVELS; l++)
      if (lvl == LW'(l)) idx = va_q[12 + 9 * (l - 1) +: 9];
  end

  wire             rd_ok    = (st == S_RD) && mem_ack;
  wire             is_leaf  = (lvl == LW'(1)) || ((lvl == LW'(2)) && mem_rdata[PS_BIT]);
  wire [E_W-1:0]   dir_upd  = mem_rdata | A_M;
  wire [E_W-1:0]   leaf_upd = mem_rdata | A_M | (wr_q ? D_M : '0);
  wire [PA_W-1:0]  pa_norm  = {mem_rdata[PA_W-1:12], va_q[11:0]};
  wire [PA_W-1:0]  pa_large = {mem_rdata[PA_W-1:22], 1'b0, va_q[20:0]};

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WDIR) || (st == S_WLEAF);
  assign mem_addr  = {base, idx, 3'b000};
  assign mem_wdata = ent_q;

  assign chk_valid = rd_ok;
  assign chk_level = lvl;
  assign chk_leaf  = is_leaf;
  assign chk_entry = is_leaf ? mem_rdata : (mem_rdata & ~PK_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lvl         <= '0;
      base        <= '0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      ent_q       <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      err_code    <= '0;
      fault_level <= '0;
      pa          <= '0;
      leaf_entry  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q <= vaddr;
          wr_q <= acc_write;
          base <= root_base[PA_W-1:12];
          lvl  <= LW'(LEVELS);
          st   <= S_RD;
        end
        S_RD: if (mem_ack) begin
          if (chk_fault) begin
            done        <= 1'b1;
            fault       <= 1'b1;
            err_code    <= chk_code;
            fault_level <= lvl;
            pa          <= '0;
            leaf_entry  <= '0;
            st          <= S_IDLE;
          end else if (!is_leaf) begin
            if (!mem_rdata[A_BIT]) begin
              ent_q <= dir_upd;
              st    <= S_WDIR;
            end else begin
              base <= mem_rdata[PA_W-1:12];
              lvl  <= lvl - 1'b1;
            end
          end else begin
            pa         <= (lvl == LW'(2)) ? pa_large : pa_norm;
            leaf_entry <= leaf_upd;
            ent_q      <= leaf_upd;
            if (leaf_upd != mem_rdata) begin
              st <= S_WLEAF;
            end else begin
              done        <= 1'b1;
              fault       <= 1'b0;
              err_code    <= '0;
              fault_level <= '0;
              st          <= S_IDLE;
            end
          end
        end
        S_WDIR: if (mem_ack) begin
          base <= ent_q[PA_W-1:12];
          lvl  <= lvl - 1'b1;
          st   <= S_RD;
        end
        default: if (mem_ack) begin
          done        <= 1'b1;
          fault       <= 1'b0;
          err_code    <= '0;
          fault_level <= '0;
          st          <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/page_walker_props.sv
module page_walker_props #(
  parameter int PA_W   = 40,
  parameter int E_W    = 64,
  parameter int A_BIT  = 5,
  parameter int PK_LSB = 59
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic [PA_W-1:0] mem_addr,
  input logic [E_W-1:0]  mem_wdata,
  input logic            mem_ack,
  input logic            chk_valid,
  input logic            chk_leaf,
  input logic [E_W-1:0]  chk_entry,
  input logic            chk_fault,
  input logic            done,
  input logic            fault
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));

  p_fault_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_fault) |=> (done && fault && !mem_req));

  p_key_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_leaf) |-> (chk_entry[E_W-1:PK_LSB] == '0));

  p_wb_accessed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[A_BIT]);
endmodule

bind page_walker page_walker_props #(
  .PA_W(PA_W), .E_W(E_W), .A_BIT(A_BIT), .PK_LSB(PK_LSB)
) u_props (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .chk_valid(chk_valid), .chk_leaf(chk_leaf), .chk_entry(chk_entry),
  .chk_fault(chk_fault), .done(done), .fault(fault)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [47:0] vaddr;
  logic        acc_write;
  logic [39:0] root_base;
  logic        mem_req, mem_we;
  logic [39:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        chk_valid;
  logic [2:0]  chk_level;
  logic        chk_leaf;
  logic [63:0] chk_entry;
  logic        chk_fault;
  logic [7:0]  chk_code;
  logic        done, fault;
  logic [7:0]  err_code;
  logic [2:0]  fault_level;
  logic [39:0] pa;
  logic [63:0] leaf_entry;

  always #(CLK_NS / 2) clk = ~clk;

  page_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .acc_write(acc_write),
    .root_base(root_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .chk_valid(chk_valid), .chk_level(chk_level), .chk_leaf(chk_leaf),
    .chk_entry(chk_entry), .chk_fault(chk_fault), .chk_code(chk_code),
    .done(done), .fault(fault), .err_code(err_code), .fault_level(fault_level),
    .pa(pa), .leaf_entry(leaf_entry)
  );

  typedef struct {
    bit        we;
    bit [39:0] a;
    bit [63:0] d;
    int        lvl;
    bit        leaf;
    bit [63:0] ce;
  } xact_t;

  xact_t     q[$];
  bit [63:0] mem [bit [39:0]];
  int        n_cmp = 0, n_bad = 0, wcnt = 0, lat_seed = 0, cyc = 0;
  bit        walking = 0, acc_w = 0;
  bit        exp_fault;
  bit [7:0]  exp_err;
  int        exp_flvl;
  bit [39:0] exp_pa;
  bit [63:0] exp_leaf;
  string     ctx = "";

  function automatic bit is_fault(bit [63:0] e, bit leaf, bit w);
    return !e[0] || (leaf && w && !e[1]);
  endfunction

  function automatic bit [7:0] fcode(bit [63:0] e, int l, bit leaf, bit w);
    return {4'(l), leaf, w, e[0], 1'b1};
  endfunction

  always_comb begin
    chk_fault = 1'b0;
    chk_code  = '0;
    if (chk_valid && is_fault(chk_entry, chk_leaf, acc_w)) begin
      chk_fault = 1'b1;
      chk_code  = fcode(chk_entry, int'(chk_level), chk_leaf, acc_w);
    end
  end

  function automatic bit [63:0] rd(bit [39:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic bit [39:0] eaddr(bit [39:0] b, bit [47:0] v, int l);
    return {b[39:12], 12'd0} | 40'(((v >> (12 + 9 * (l - 1))) & 48'h1FF) << 3);
  endfunction

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic plan_walk(bit [47:0] v, bit [39:0] root, bit w);
    bit [63:0] sh [bit [39:0]];
    bit [39:0] b;
    bit        fin;
    sh  = mem;
    b   = {root[39:12], 12'd0};
    fin = 0;
    q.delete();
    for (int l = 4; l >= 1 && !fin; l--) begin
      bit [39:0] a;
      bit [63:0] e, ce, n;
      bit        lf;
      a  = eaddr(b, v, l);
      e  = sh.exists(a) ? sh[a] : 64'd0;
      lf = (l == 1) || (l == 2 && e[7]);
      ce = lf ? e : (e & 64'h07FF_FFFF_FFFF_FFFF);
      q.push_back('{we: 1'b0, a: a, d: 64'd0, lvl: l, leaf: lf, ce: ce});
      if (is_fault(ce, lf, w)) begin
        exp_fault = 1; exp_err = fcode(ce, l, lf, w); exp_flvl = l;
        exp_pa = 0; exp_leaf = 0; fin = 1;
      end else if (!lf) begin
        if (!e[5]) begin
          q.push_back('{we: 1'b1, a: a, d: e | 64'h20, lvl: l, leaf: 1'b0, ce: 64'd0});
          sh[a] = e | 64'h20;
        end
        b = {e[39:12], 12'd0};
      end else begin
        n = e | 64'h20 | (w ? 64'h40 : 64'h0);
        if (n != e) q.push_back('{we: 1'b1, a: a, d: n, lvl: l, leaf: 1'b1, ce: 64'd0});
        if (l == 2) exp_pa = {e[39:22], 1'b0, v[20:0]};
        else        exp_pa = {e[39:12], v[11:0]};
        exp_fault = 0; exp_err = 0; exp_flvl = 0; exp_leaf = n; fin = 1;
      end
    end
  endtask

  task automatic tick();
    bit last;
    @(negedge clk);
    cyc++;
    start = 1'b0;
    last  = 0;
    if (mem_ack) begin
      xact_t h;
      h = q.pop_front();
      if (h.we) mem[h.a] = h.d;
      wcnt = 0;
      lat_seed++;
      if (q.size() == 0) last = 1;
    end
    mem_ack = 1'b0;
    if (walking) begin
      cmp("R9 done timing", done, last);
      if (last) begin
        cmp("R6 fault flag", fault, exp_fault);
        cmp("R6 error code", err_code, exp_err);
        cmp("R6 fault level", fault_level, exp_flvl);
        if (!exp_fault) begin
          cmp("R7 physical address", pa, exp_pa);
          cmp("R5 leaf entry", leaf_entry, exp_leaf);
        end
        walking = 0;
      end
    end else begin
      cmp("R9 no stray done", done, 0);
    end
    if (walking) begin
      cmp("R11 request present", mem_req, 1);
      cmp("R1/R2 entry address", mem_addr, q[0].a);
      cmp("R4/R5 write kind", mem_we, q[0].we);
      if (q[0].we) cmp("R4/R5 write data", mem_wdata, q[0].d);
      if (wcnt >= lat_seed % 3) begin
        mem_ack   = 1'b1;
        mem_rdata = q[0].we ? 64'd0 : rd(q[0].a);
      end else begin
        wcnt++;
      end
    end else begin
      cmp("R12 no request when idle", mem_req, 0);
    end
    #1;
    if (mem_ack && walking && !q[0].we) begin
      cmp("R3 checker valid", chk_valid, 1);
      cmp("R3 checker level", chk_level, q[0].lvl);
      cmp("R3 leaf decision", chk_leaf, q[0].leaf);
      cmp("R8 checker entry", chk_entry, q[0].ce);
    end else begin
      cmp("R3 checker quiet", chk_valid, 0);
    end
  endtask

  task automatic run_walk(string c, bit [47:0] v, bit [39:0] root, bit w, int inject);
    int g;
    tick();
    ctx = c;
    acc_w = w;
    plan_walk(v, root, w);
    vaddr = v; root_base = root; acc_write = w; start = 1'b1;
    walking = 1;
    g = 0;
    while (walking && g < 300) begin
      tick();
      g++;
      if (g == inject) begin
        // R10: a start pulse with a different request while busy
        start = 1'b1; vaddr = 48'hFF80_0000_0000; acc_write = ~w;
      end
    end
    if (walking) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog [%s] actual=hung expected=done", ctx);
      walking = 0; q.delete(); mem_ack = 1'b0;
    end
  endtask

  task automatic put(bit [39:0] b, bit [47:0] v, int l, bit [63:0] val);
    mem[eaddr(b, v, l)] = val;
  endtask

  localparam bit [39:0] ROOT = 40'h00_0010_0000;
  localparam bit [47:0] V1 = 48'h1234_5678_9ABC;
  localparam bit [47:0] V2 = 48'h0ABC_DE60_0123;
  localparam bit [47:0] V3 = 48'h7000_0000_0000;
  localparam bit [47:0] V4 = 48'h1234_5678_AABC;
  localparam bit [47:0] V5 = 48'hFF80_0000_0000;

  initial begin
    rst_n = 1'b0; start = 1'b0; vaddr = '0; acc_write = 1'b0; root_base = '0;
    mem_ack = 1'b0; mem_rdata = '0;

    put(ROOT, V1, 4, 64'h0000_0000_0020_0007);
    put(40'h0020_0000, V1, 3, 64'h0000_0000_0030_0007);
    put(40'h0030_0000, V1, 2, 64'h0000_0000_0040_0007);
    put(40'h0040_0000, V1, 1, 64'h0800_0012_3456_7007);
    put(40'h0040_0000, V4, 1, 64'h0000_0012_3457_7025);
    put(ROOT, V2, 4, 64'h1800_0000_0050_0007);
    put(40'h0050_0000, V2, 3, 64'h2000_0000_0060_0027);
    put(40'h0060_0000, V2, 2, 64'h0800_007F_E000_0087);
    put(ROOT, V3, 4, 64'h0000_0000_0070_0027);

    repeat (2) @(negedge clk);
    cmp("R12 reset done", done, 0);
    cmp("R12 reset request", mem_req, 0);
    rst_n = 1'b1;
    tick();
    cmp("R12 idle after reset", mem_req, 0);

    run_walk("R1 R4 R5 four-level read, all accessed bits clear", V1, ROOT, 1'b0, 0);
    run_walk("R4 R5 repeat read, nothing to update", V1, ROOT, 1'b0, 0);
    run_walk("R5 write sets dirty", V1, ROOT, 1'b1, 0);
    run_walk("R3 R7 R8 large page with keys in upper levels", V2, ROOT, 1'b0, 0);
    run_walk("R6 missing level-3 entry", V3, ROOT, 1'b0, 0);
    run_walk("R6 write to read-only leaf", V4, ROOT, 1'b1, 0);
    run_walk("R6 missing level-4 entry", V5, ROOT, 1'b0, 0);
    run_walk("R10 start while busy, large write", V2, ROOT, 1'b1, 2);
    run_walk("R7 normal read-only leaf read", V4, ROOT, 1'b0, 0);
    repeat (3) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule